// File: doc/BRIEF.md
# Bus Activity and Address Match Monitor

This block watches the data and clock lines of a two-wire serial bus of the I2C kind. Each line first passes through its own synchronizer chain. A start condition is a data falling edge while the clock stays high. A stop condition is a data rising edge while the clock stays high. The block turns each of these into a single-cycle pulse.

After every start or repeated start, the block shifts in the next eight data bits, most significant bit first, on clock rising edges. It compares the upper seven bits with a programmed slave address. It also compares the whole byte with the all-zero general-call address. From these events it keeps four flags:

- a bus-busy flag driven by line levels;
- an address-match flag;
- a general-call-match flag;
- a controller-busy flag, which covers start generation, master mode, an active match, and the window in which the address byte is being received.

A controller that owns the bus uses these flags to decide when it may take the bus and when it has been addressed as a slave. Data phases after the address byte and acknowledge driving are handled elsewhere.

Top module: `bus_addr_monitor`

## Requirements
- R1: A data falling edge with the clock high on two consecutive synchronized samples gives exactly one `start_pulse`. A data rising edge under the same clock condition gives exactly one `stop_pulse`. Neither pulse is produced while `enable` is 0.
- R2: `bus_busy` sets when either synchronized line is low, or when a start is detected.
- R3: `bus_busy` clears on a stop, and in the cycle after a `bb_clr_wr` pulse. The clear wins over any set condition in that cycle.
- R4: After a start, the next eight clock rising edges sample the data line. The first sampled bit becomes bit 7 of the address byte. The byte is complete after the eighth bit.
- R5: `addr_match` sets when the byte completes only if `addr_en` is 1 and byte bits 7:1 equal `slave_addr`. Bit 0, the direction bit, is ignored.
- R6: `gc_match` sets when the byte completes only if `gc_en` is 1 and the whole byte is 8'h00.
- R7: Both match flags clear on a start, a repeated start, or a stop. This includes a start or stop that arrives in the middle of the address byte.
- R8: `mod_busy` is 1 while `start_gen` is 1, while `master_mode` is 1, while either match flag is set, or from a detected start until the address byte completes. It is 0 otherwise.
- R9: While `enable` is 0, all four flags read 0.
- R10: Once the address byte has completed, further clock and data activity that contains no start or stop leaves both match flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_i | input | 1 | Raw data line sample |
| scl_i | input | 1 | Raw clock line sample |
| enable | input | 1 | Module enable; 0 clears all state |
| slave_addr | input | 7 | Programmed slave address |
| addr_en | input | 1 | Slave address matching enable |
| gc_en | input | 1 | General-call matching enable |
| master_mode | input | 1 | Controller is acting as bus master |
| start_gen | input | 1 | Controller is generating a start |
| bb_clr_wr | input | 1 | Single-cycle software write of 1 to the bus-busy flag |
| bus_busy | output | 1 | Bus activity flag |
| addr_match | output | 1 | Slave address matched |
| gc_match | output | 1 | General-call address matched |
| mod_busy | output | 1 | Controller busy flag |
| start_pulse | output | 1 | One-cycle start/repeated-start event |
| stop_pulse | output | 1 | One-cycle stop event |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and a 7-bit address inside an 8-bit byte. With these values every one of the 128 slave addresses and both direction bits can be reached by random address bytes. Idle periods of a few cycles are enough to cover the full synchronizer-plus-edge latency. The random bytes are biased toward exact hits and toward 8'h00, so that the matching rules are exercised under every combination of the two enables. Directed sequences add an abort in the middle of the byte, a repeated start after a match, a software clear while a line is held low, and disable during a match.

// File: rtl/bam_pkg.sv
package bam_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;

  // Upper bits of the received byte carry the address; bit 0 is direction.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] rx,
                                    input logic [ADDR_W-1:0] own,
                                    input logic              en);
    return en && (rx[BYTE_W-1:1] == own);
  endfunction

  function automatic logic gc_hit(input logic [BYTE_W-1:0] rx,
                                  input logic              en);
    return en && (rx == '0);
  endfunction
endpackage

// File: rtl/bam_sync.sv
module bam_sync #(
  parameter int   STAGES  = 2,
  parameter logic IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= IDLE_LV;
        else if (g == 0) chain[g] <= d_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bam_cond.sv
module bam_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sda,
  input  logic scl,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o
);
  logic sda_q, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda;
      scl_q <= scl;
    end
  end

  logic clk_high;
  assign clk_high   = scl & scl_q;
  assign start_o    = en & clk_high & sda_q & ~sda;
  assign stop_o     = en & clk_high & ~sda_q & sda;
  assign scl_rise_o = en & ~scl_q & scl;

  // R1
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && stop_o));
  // R1
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
endmodule

// File: rtl/bam_addr.sv
module bam_addr
  import bam_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              stop,
  input  logic              scl_rise,
  input  logic              sda,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr_en,
  input  logic              gc_en,
  output logic              collecting,
  output logic              addr_match,
  output logic              gc_match
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg_nxt;
  logic              byte_done;

  assign shreg_nxt = {shreg[BYTE_W-2:0], sda};
  assign byte_done = collecting && scl_rise && (bit_cnt == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; bit_cnt <= '0; collecting <= 1'b0;
      addr_match <= 1'b0; gc_match <= 1'b0;
    end else if (!en) begin
      shreg <= '0; bit_cnt <= '0; collecting <= 1'b0;
      addr_match <= 1'b0; gc_match <= 1'b0;
    end else if (start) begin
      bit_cnt <= '0; collecting <= 1'b1;
      addr_match <= 1'b0; gc_match <= 1'b0;
    end else if (stop) begin
      bit_cnt <= '0; collecting <= 1'b0;
      addr_match <= 1'b0; gc_match <= 1'b0;
    end else if (collecting && scl_rise) begin
      shreg   <= shreg_nxt;
      bit_cnt <= bit_cnt + 1'b1;
      if (byte_done) begin
        collecting <= 1'b0;
        addr_match <= addr_hit(shreg_nxt, own_addr, addr_en);
        gc_match   <= gc_hit(shreg_nxt, gc_en);
      end
    end
  end

  // R4
  byte_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && en && !start && !stop |=> !collecting);
  // R7
  clr_on_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start || stop) |=> !addr_match && !gc_match);
  // R5
  match_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_match) |-> $past(addr_en) && $past(byte_done));
  // R6
  gc_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gc_match) |-> $past(gc_en) && $past(byte_done));
  // R10
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !start && !stop && !collecting |=> $stable(addr_match) && $stable(gc_match));
endmodule

// File: rtl/bus_addr_monitor.sv
module bus_addr_monitor
  import bam_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic              enable,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic              addr_en,
  input  logic              gc_en,
  input  logic              master_mode,
  input  logic              start_gen,
  input  logic              bb_clr_wr,
  output logic              bus_busy,
  output logic              addr_match,
  output logic              gc_match,
  output logic              mod_busy,
  output logic              start_pulse,
  output logic              stop_pulse
);
  logic sda_s, scl_s, scl_rise, collecting;

  bam_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));
  bam_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));

  bam_cond u_cond (
    .clk(clk), .rst_n(rst_n), .en(enable), .sda(sda_s), .scl(scl_s),
    .start_o(start_pulse), .stop_o(stop_pulse), .scl_rise_o(scl_rise));

  bam_addr u_addr (
    .clk(clk), .rst_n(rst_n), .en(enable), .start(start_pulse),
    .stop(stop_pulse), .scl_rise(scl_rise), .sda(sda_s),
    .own_addr(slave_addr), .addr_en(addr_en), .gc_en(gc_en),
    .collecting(collecting), .addr_match(addr_match), .gc_match(gc_match));

  logic line_low, bb_set, bb_clr;
  assign line_low = ~sda_s | ~scl_s;
  assign bb_set   = line_low | start_pulse;
  assign bb_clr   = ~enable | stop_pulse | bb_clr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_busy <= 1'b0;
    else if (bb_clr) bus_busy <= 1'b0;
    else if (bb_set) bus_busy <= 1'b1;
  end

  assign mod_busy = enable & (start_gen | master_mode | addr_match | gc_match | collecting);

  // R3
  bb_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bb_clr_wr |=> !bus_busy);
  // R2
  bb_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse && enable && !bb_clr_wr |=> bus_busy);
  // R9
  disable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !bus_busy && !addr_match && !gc_match);
  // R8
  mb_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse && enable |=> mod_busy || !enable);
endmodule

// File: tb/tb_bus_addr_monitor.sv
`timescale 1ns/1ps
module tb_bus_addr_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sda_i = 1'b1, scl_i = 1'b1, enable = 1'b0;
  logic [6:0] slave_addr = 7'h00;
  logic addr_en = 1'b0, gc_en = 1'b0, master_mode = 1'b0, start_gen = 1'b0, bb_clr_wr = 1'b0;
  logic bus_busy, addr_match, gc_match, mod_busy, start_pulse, stop_pulse;

  int n_chk = 0, n_fail = 0, n_start = 0, n_stop = 0;

  always #5 clk = ~clk;

  bus_addr_monitor dut (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_i), .scl_i(scl_i), .enable(enable),
    .slave_addr(slave_addr), .addr_en(addr_en), .gc_en(gc_en),
    .master_mode(master_mode), .start_gen(start_gen), .bb_clr_wr(bb_clr_wr),
    .bus_busy(bus_busy), .addr_match(addr_match), .gc_match(gc_match),
    .mod_busy(mod_busy), .start_pulse(start_pulse), .stop_pulse(stop_pulse));

  always @(negedge clk) begin
    if (start_pulse) n_start++;
    if (stop_pulse)  n_stop++;
  end

  function automatic logic exp_addr(input logic [7:0] b, input logic [6:0] a, input logic en);
    return en && ((b >> 1) == {1'b0, a});
  endfunction
  function automatic logic exp_gc(input logic [7:0] b, input logic en);
    return en && (b == 8'd0);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_i = 1'b1; hold(1); scl_i = 1'b1; hold(5);
    sda_i = 1'b0; hold(5);
    scl_i = 1'b0; hold(5);
  endtask
  task automatic bus_bit(input logic b);
    sda_i = b; hold(5); scl_i = 1'b1; hold(5); scl_i = 1'b0; hold(5);
  endtask
  task automatic bus_stop();
    sda_i = 1'b0; hold(5); scl_i = 1'b1; hold(5); sda_i = 1'b1; hold(6);
  endtask
  task automatic bus_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    hold(3);
    chk_eq("R9 reset bus_busy", bus_busy, 0);
    chk_eq("R9 reset mod_busy", mod_busy, 0);
    rst_n = 1'b1; hold(2);
    bus_start();
    chk_eq("R1 no start while disabled", n_start, 0);
    chk_eq("R9 disabled bus_busy", bus_busy, 0);
    bus_stop();
    enable = 1'b1; hold(4);
    chk_eq("R2 idle bus_busy", bus_busy, 0);

    // directed: matched address with direction 1
    slave_addr = 7'h5A; addr_en = 1'b1; gc_en = 1'b1;
    n_start = 0; n_stop = 0;
    bus_start();
    chk_eq("R1 one start pulse", n_start, 1);
    chk_eq("R2 busy after start", bus_busy, 1);
    chk_eq("R8 busy while collecting", mod_busy, 1);
    bus_byte({7'h5A, 1'b1});
    chk_eq("R4/R5 match MSB first", addr_match, 1);
    chk_eq("R6 no gc on nonzero", gc_match, 0);
    bus_bit(1'b0);
    bus_byte(8'h00);
    chk_eq("R10 data byte keeps match", addr_match, 1);
    chk_eq("R10 data 00 no gc", gc_match, 0);
    // repeated start
    sda_i = 1'b1; hold(5); scl_i = 1'b1; hold(5); sda_i = 1'b0; hold(5);
    chk_eq("R7 repeated start clears", addr_match, 0);
    chk_eq("R8 collecting after repeated start", mod_busy, 1);
    scl_i = 1'b0; hold(5);
    // abort mid-byte
    bus_bit(1'b0); bus_bit(1'b0); bus_bit(1'b0);
    bus_stop();
    chk_eq("R1 one stop pulse", n_stop, 1);
    chk_eq("R7 mid-byte stop no match", addr_match | gc_match, 0);
    chk_eq("R8 idle after stop", mod_busy, 0);
    chk_eq("R3 stop clears bus_busy", bus_busy, 0);

    // software clear while clock held low
    scl_i = 1'b0; hold(5);
    chk_eq("R2 low line sets busy", bus_busy, 1);
    bb_clr_wr = 1'b1; @(negedge clk); bb_clr_wr = 1'b0;
    chk_eq("R3 write clear wins", bus_busy, 0);
    hold(2);
    chk_eq("R2 low line re-sets busy", bus_busy, 1);
    scl_i = 1'b1; hold(5);

    // master / start generation
    master_mode = 1'b1; hold(1);
    chk_eq("R8 master mode busy", mod_busy, 1);
    master_mode = 1'b0; start_gen = 1'b1; hold(1);
    chk_eq("R8 start_gen busy", mod_busy, 1);
    start_gen = 1'b0; hold(1);
    chk_eq("R8 clears when none", mod_busy, 0);

    // disable during general-call match
    bus_start(); bus_byte(8'h00);
    chk_eq("R6 gc on 00", gc_match, 1);
    enable = 1'b0; hold(2);
    chk_eq("R9 disable clears gc", gc_match, 0);
    chk_eq("R9 disable clears mod_busy", mod_busy, 0);
    chk_eq("R9 disable clears bus_busy", bus_busy, 0);
    bus_stop(); enable = 1'b1; hold(4);

    // constrained random
    void'($urandom(32'h1234_5678));
    for (int it = 0; it < 60; it++) begin
      logic [7:0] b;
      int kind;
      slave_addr = 7'($urandom);
      addr_en = 1'($urandom);
      gc_en = 1'($urandom);
      kind = $urandom_range(0, 2);
      if (kind == 0)      b = {slave_addr, 1'($urandom)};
      else if (kind == 1) b = 8'h00;
      else                b = 8'($urandom);
      bus_start();
      bus_byte(b);
      chk_eq("R5 random addr_match", addr_match, exp_addr(b, slave_addr, addr_en));
      chk_eq("R6 random gc_match", gc_match, exp_gc(b, gc_en));
      chk_eq("R8 random mod_busy", mod_busy,
             exp_addr(b, slave_addr, addr_en) | exp_gc(b, gc_en));
      bus_bit(1'b0);
      bus_byte(8'($urandom));
      chk_eq("R10 random hold", addr_match, exp_addr(b, slave_addr, addr_en));
      bus_stop();
      chk_eq("R7 random stop clears", addr_match | gc_match, 0);
      chk_eq("R3 random stop bus_busy", bus_busy, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule